// File: doc/BRIEF.md
# Dual Programmable Interval Timer Pair

This block holds two 16-bit down-counting timers that a processor reaches through a 4-bit register-select bus with an 8-bit data path. Each bus access is either a write or a read of one byte. Six select codes reach the timers. Some of them have side effects: a write can load a counter or clear an interrupt flag, and a read can clear a flag.

The primary timer has a full 16-bit reload latch. It runs in one of four modes. It can stop flagging after its first time-out or reload itself and flag on every time-out. An optional output pin gives either a single low pulse or a square wave. The secondary timer counts system clock cycles as a one-shot interval timer, or it counts falling edges on an external pulse input. The input is synchronised before its edges are detected. Mode selection arrives on dedicated input pins. Each timer drives one interrupt flag output.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both interrupt flags are 0, the primary timer's latch bytes (select 6 and 7) read back 0, and the output pin is high.
- R2: A write to select 4 or 6 updates only the primary low latch byte. A write to select 7 updates only the primary high latch byte and clears the primary flag. Neither of these writes alters the primary counter.
- R3: A write to select 5 puts the data byte into the high latch and loads the counter with {data, low latch}. The same write clears the primary flag and arms the timer. When N is loaded, the flag reads 1 exactly N+1 clock edges after the load edge.
- R4: A read returns the primary counter low byte on select 4, the counter high byte on select 5, the low latch on select 6 and the high latch on select 7. A read of select 4 clears the primary flag.
- R5: In a one-shot mode (mode bit 0 = 0), only the first time-out after a load sets the flag. The counter wraps to all ones and keeps decrementing without raising the flag again.
- R6: In free-run mode (mode bit 0 = 1), each time-out reloads the counter from the 16-bit latch and sets the flag. With latch value N, time-outs recur every N+1 cycles.
- R7: When mode bit 1 = 1, the output pin goes low on the select 5 write. In mode 2'b10 it goes high at the first time-out and stays high. In mode 2'b11 it inverts at every time-out. When mode bit 1 = 0, the pin is high.
- R8: For the secondary timer, a write to select 8 sets its low latch. A write to select 9 loads the counter with {data, low latch}, clears its flag and arms it. A read of select 8 returns the counter low byte and clears the flag. A read of select 9 returns the counter high byte.
- R9: In interval mode (count-mode pin = 0), the secondary timer decrements every cycle. Only its first time-out after a load sets its flag, N+1 edges after loading N. It then wraps to all ones.
- R10: In count mode (count-mode pin = 1), the secondary counter decrements once per falling edge of the pulse input and ignores rising edges. Its flag sets on the falling edge that takes it past zero.
- R11: A time-out in the same cycle as a flag-clearing access (read of select 4, write of select 7) leaves the flag set. A counter load in the same cycle as a time-out wins: the loaded value is taken and no time-out occurs.
- R12: Writes to select codes 0-3 and 10-15 change nothing. Reads of those codes return 0, and the read data is 0 whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Register select code |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from sel |
| t1_mode | input | 2 | Primary mode: bit 0 free-run, bit 1 output pin enable |
| t2_count_mode | input | 1 | Secondary timer counts pulse input edges when 1 |
| pulse_in | input | 1 | Asynchronous pulse input for the secondary timer |
| t1_out | output | 1 | Primary timer output pin |
| t1_irq | output | 1 | Primary interrupt flag |
| t2_irq | output | 1 | Secondary interrupt flag |

## Verification
Two pairs of events can fall in one cycle. A time-out can coincide with a bus access that clears the flag, and a high-byte load can coincide with a time-out. The bench computes the time-out cycle of a free-running load as a multiple of N+1 after the load edge. It places a select 4 read, a select 7 write or a select 5 write in exactly that cycle. The first two must leave the flag standing on the next edge. The third must leave the flag clear and the counter holding the new value, which a read of select 5 confirms.

// File: rtl/dit_pkg.sv
package dit_pkg;

   localparam int unsigned SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      A_T1_CLO = 4'd4,
      A_T1_CHI = 4'd5,
      A_T1_LLO = 4'd6,
      A_T1_LHI = 4'd7,
      A_T2_LO  = 4'd8,
      A_T2_HI  = 4'd9
   } dit_addr_e;

   typedef struct packed {
      logic t1_lat_lo;
      logic t1_lat_hi;
      logic t1_load;
      logic t1_clr;
      logic t2_lat_lo;
      logic t2_load;
      logic t2_clr;
   } dit_strobe_t;

endpackage

// File: rtl/dit_regdecode.sv
module dit_regdecode
   import dit_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2*DW-1:0]  t1_cnt,
   input  logic [2*DW-1:0]  t1_lat,
   input  logic [2*DW-1:0]  t2_cnt,
   output dit_strobe_t      stb,
   output logic [DW-1:0]    rdata
);

   localparam int TW = 2 * DW;

   logic hit4, hit5, hit6, hit7, hit8, hit9;

   assign hit4 = (sel == A_T1_CLO);
   assign hit5 = (sel == A_T1_CHI);
   assign hit6 = (sel == A_T1_LLO);
   assign hit7 = (sel == A_T1_LHI);
   assign hit8 = (sel == A_T2_LO);
   assign hit9 = (sel == A_T2_HI);

   always_comb begin
      stb.t1_lat_lo = wr_en && (hit4 || hit6);
      stb.t1_lat_hi = wr_en && (hit5 || hit7);
      stb.t1_load   = wr_en && hit5;
      stb.t1_clr    = (wr_en && (hit5 || hit7)) || (rd_en && hit4);
      stb.t2_lat_lo = wr_en && hit8;
      stb.t2_load   = wr_en && hit9;
      stb.t2_clr    = (wr_en && hit9) || (rd_en && hit8);
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            A_T1_CLO: rdata = t1_cnt[DW-1:0];
            A_T1_CHI: rdata = t1_cnt[TW-1:DW];
            A_T1_LLO: rdata = t1_lat[DW-1:0];
            A_T1_LHI: rdata = t1_lat[TW-1:DW];
            A_T2_LO:  rdata = t2_cnt[DW-1:0];
            A_T2_HI:  rdata = t2_cnt[TW-1:DW];
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/dit_timer_core.sv
module dit_timer_core #(
   parameter int DW     = 8,
   parameter bit RELOAD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   wdata,
   input  logic            lat_lo_we,
   input  logic            lat_hi_we,
   input  logic            load,
   input  logic            clr,
   input  logic            tick,
   input  logic            free_run,
   output logic [2*DW-1:0] cnt,
   output logic [2*DW-1:0] latch,
   output logic            hit,
   output logic            flag
);

   localparam int TW = 2 * DW;
   localparam logic [TW-1:0] ONE = TW'(1);

   logic [DW-1:0] lat_lo_q;
   logic [DW-1:0] lat_hi_q;
   logic [TW-1:0] cnt_q;
   logic          armed_q;
   logic          flag_q;
   logic          free_eff;
   logic          expire;

   always_ff @(posedge clk) begin
      if (!rst_n)         lat_lo_q <= '0;
      else if (lat_lo_we) lat_lo_q <= wdata;
   end

   generate
      if (RELOAD) begin : g_reload
         always_ff @(posedge clk) begin
            if (!rst_n)         lat_hi_q <= '0;
            else if (lat_hi_we) lat_hi_q <= wdata;
         end
         assign free_eff = free_run;
      end else begin : g_plain
         logic unused_ok;
         assign lat_hi_q  = '0;
         assign free_eff  = 1'b0;
         assign unused_ok = lat_hi_we ^ free_run;
      end
   endgenerate

   assign expire = tick && (cnt_q == '0) && !load;
   assign hit    = expire && (armed_q || free_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= {wdata, lat_lo_q};
         armed_q <= 1'b1;
      end else if (expire && free_eff) begin
         cnt_q   <= {lat_hi_q, lat_lo_q};
      end else if (tick) begin
         cnt_q   <= cnt_q - ONE;
         if (expire) armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (hit) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign cnt   = cnt_q;
   assign latch = {lat_hi_q, lat_lo_q};
   assign flag  = flag_q;

endmodule

// File: rtl/dit_edge_sync.sv
module dit_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("dit_edge_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sh_q[STAGES-1];
   end

   assign fall = last_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/dit_t1_pin.sv
module dit_t1_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       hit,
   input  logic [1:0] mode,
   output logic       pin
);

   logic pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    pin_q <= 1'b1;
      else if (load) pin_q <= 1'b0;
      else if (hit)  pin_q <= mode[0] ? ~pin_q : 1'b1;
   end

   assign pin = mode[1] ? pin_q : 1'b1;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [1:0]       t1_mode,
   input  logic             t2_count_mode,
   input  logic             pulse_in,
   output logic             t1_out,
   output logic             t1_irq,
   output logic             t2_irq
);

   localparam int TW = 2 * DW;

   generate
      if (DW < 4) begin : g_bad_dw
         $error("dual_interval_timer: DW must be at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("dual_interval_timer: SYNC_STAGES must be at least 1");
      end
   endgenerate

   dit_strobe_t   stb;
   logic [TW-1:0] t1_cnt, t1_lat, t2_cnt, t2_latch_unused;
   logic          t1_hit, t2_hit_unused, t2_fall, t2_tick;

   dit_regdecode #(.DW(DW)) u_dec (
      .sel    (sel),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .t1_cnt (t1_cnt),
      .t1_lat (t1_lat),
      .t2_cnt (t2_cnt),
      .stb    (stb),
      .rdata  (rdata)
   );

   dit_timer_core #(.DW(DW), .RELOAD(1'b1)) u_t1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wdata     (wdata),
      .lat_lo_we (stb.t1_lat_lo),
      .lat_hi_we (stb.t1_lat_hi),
      .load      (stb.t1_load),
      .clr       (stb.t1_clr),
      .tick      (1'b1),
      .free_run  (t1_mode[0]),
      .cnt       (t1_cnt),
      .latch     (t1_lat),
      .hit       (t1_hit),
      .flag      (t1_irq)
   );

   dit_t1_pin u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (stb.t1_load),
      .hit   (t1_hit),
      .mode  (t1_mode),
      .pin   (t1_out)
   );

   dit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pulse_in),
      .fall  (t2_fall)
   );

   assign t2_tick = t2_count_mode ? t2_fall : 1'b1;

   dit_timer_core #(.DW(DW), .RELOAD(1'b0)) u_t2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wdata     (wdata),
      .lat_lo_we (stb.t2_lat_lo),
      .lat_hi_we (1'b0),
      .load      (stb.t2_load),
      .clr       (stb.t2_clr),
      .tick      (t2_tick),
      .free_run  (1'b0),
      .cnt       (t2_cnt),
      .latch     (t2_latch_unused),
      .hit       (t2_hit_unused),
      .flag      (t2_irq)
   );

endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    sel,
   input logic          wr_en,
   input logic          rd_en,
   input logic [DW-1:0] rdata,
   input logic [1:0]    t1_mode,
   input logic          t1_out,
   input logic          t1_irq,
   input logic          t2_irq
);

   // R3: a high-byte load always leaves the primary flag clear
   a_r3_load_clears_t1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 4'd5) |=> !t1_irq);

   // R8: a secondary load always leaves its flag clear
   a_r8_load_clears_t2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 4'd9) |=> !t2_irq);

   // R7: an enabled pin is low right after a load
   a_r7_pin_low_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 4'd5 && t1_mode[1]) |=> (!t1_out || !t1_mode[1]));

   // R7: in pulse mode the pin only falls because of a load
   a_r7_pulse_falls_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_mode == 2'b10 && $past(t1_mode) == 2'b10 && $fell(t1_out))
         |-> $past(wr_en && sel == 4'd5));

   // R12: read data is zero without a read request
   a_r12_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

   // R12: unmapped codes read as zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (sel < 4'd4 || sel > 4'd9)) |-> (rdata == '0));

endmodule

bind dual_interval_timer dual_interval_timer_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (sel),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .rdata   (rdata),
   .t1_mode (t1_mode),
   .t1_out  (t1_out),
   .t1_irq  (t1_irq),
   .t2_irq  (t2_irq)
);

// File: tb/dual_interval_timer_test.sv
`timescale 1ns/1ps
module dual_interval_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] sel = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0] t1_mode = 2'b10;
   logic       t2_count_mode = 1'b0;
   logic       pulse_in = 1'b1;
   logic       t1_out, t1_irq, t2_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dual_interval_timer uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .t1_mode(t1_mode),
      .t2_count_mode(t2_count_mode), .pulse_in(pulse_in),
      .t1_out(t1_out), .t1_irq(t1_irq), .t2_irq(t2_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      sel = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sel = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      sel = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; sel = '0;
   endtask

   task automatic pulse();
      pulse_in = 1'b0; tick(4);
      pulse_in = 1'b1; tick(4);
   endtask

   initial begin
      #(1_500_000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk("R1 t1_irq", t1_irq, 0);
      chk("R1 t2_irq", t2_irq, 0);
      chk("R1 t1_out", t1_out, 1);
      rd(4'd6, d); chk("R1 latch lo", d, 0);
      rd(4'd7, d); chk("R1 latch hi", d, 0);

      // R12 unmapped codes and idle bus
      sel = 4'd5; #1 chk("R12 idle rdata", rdata, 0); sel = '0;
      for (int a = 0; a < 16; a++) begin
         if (a < 4 || a > 9) begin
            rd(a[3:0], d); chk("R12 unmapped read", d, 0);
         end
      end
      wr(4'd2, 8'hAA); wr(4'd12, 8'h55); wr(4'd15, 8'h33);
      rd(4'd6, d); chk("R12 latch lo untouched", d, 0);
      rd(4'd7, d); chk("R12 latch hi untouched", d, 0);

      // R2/R4 latch writes, mode 10 one-shot with pulse
      wr(4'd4, 8'h07); rd(4'd6, d); chk("R2 sel4 writes latch lo", d, 8'h07);
      wr(4'd6, 8'h05); rd(4'd6, d); chk("R2 sel6 writes latch lo", d, 8'h05);
      wr(4'd7, 8'h00); rd(4'd7, d); chk("R4 latch hi read", d, 8'h00);
      wr(4'd5, 8'h00);                               // m=0, N=5
      chk("R7 pin low after load", t1_out, 0);
      chk("R3 flag clear after load", t1_irq, 0);
      rd(4'd4, d); chk("R4 counter lo", d, 8'h05);  // m=1
      tick(4);                                       // m=5
      chk("R3 no flag at N", t1_irq, 0);
      chk("R7 pin low before timeout", t1_out, 0);
      tick(1);                                       // m=6
      chk("R3 flag at N+1", t1_irq, 1);
      chk("R7 pulse ends at timeout", t1_out, 1);
      rd(4'd5, d); chk("R5 wrap to all ones", d, 8'hFF);   // m=7
      rd(4'd4, d); chk("R5 keeps counting", d, 8'hFE);     // m=8
      chk("R4 read sel4 clears flag", t1_irq, 0);
      tick(65540);                                   // past second zero
      chk("R5 no second flag", t1_irq, 0);
      chk("R7 pulse pin stays high", t1_out, 1);
      rd(4'd5, d); chk("R5 counter still running", d, 8'hFF);

      // R2 latch writes leave the counter alone
      wr(4'd4, 8'h30); wr(4'd5, 8'h01);              // m=0, 0x130
      rd(4'd5, d); chk("R4 counter hi", d, 8'h01);   // m=1
      wr(4'd7, 8'h44);                               // m=2
      rd(4'd7, d); chk("R2 sel7 writes latch hi", d, 8'h44); // m=3
      rd(4'd5, d); chk("R2 counter hi unchanged", d, 8'h01); // m=4
      rd(4'd4, d); chk("R2 counter lo after sel7", d, 8'h2C);// m=5
      wr(4'd6, 8'h99);                               // m=6
      rd(4'd4, d); chk("R2 counter lo after sel6", d, 8'h2A);// m=7
      rd(4'd6, d); chk("R2 latch lo updated", d, 8'h99);

      // R6/R7/R11 free-run square wave, N=3
      t1_mode = 2'b11;
      wr(4'd4, 8'h03); wr(4'd5, 8'h00);              // m=0
      tick(3);                                       // m=3
      chk("R6 no flag before N+1", t1_irq, 0);
      chk("R7 square low", t1_out, 0);
      tick(1);                                       // m=4
      chk("R6 flag at first timeout", t1_irq, 1);
      chk("R7 square toggles high", t1_out, 1);
      rd(4'd4, d); chk("R6 reload from latch", d, 8'h03);   // m=5
      chk("R4 flag cleared by read", t1_irq, 0);
      tick(2);                                       // m=7
      chk("R7 square holds high", t1_out, 1);
      tick(1);                                       // m=8
      chk("R6 flag at second timeout", t1_irq, 1);
      chk("R7 square toggles low", t1_out, 0);
      wr(4'd7, 8'h00);                               // m=9
      chk("R2 sel7 clears flag", t1_irq, 0);
      tick(2);                                       // m=11
      rd(4'd4, d); chk("R6 counter at zero", d, 8'h00);     // m=12
      chk("R11 set wins over read clear", t1_irq, 1);
      chk("R7 third toggle", t1_out, 1);
      tick(3);                                       // m=15
      wr(4'd7, 8'h00);                               // m=16
      chk("R11 set wins over sel7 clear", t1_irq, 1);
      tick(3);                                       // m=19
      wr(4'd5, 8'h01);                               // m=20 load at timeout
      chk("R11 load wins, flag clear", t1_irq, 0);
      chk("R7 load drives pin low", t1_out, 0);
      rd(4'd5, d); chk("R11 loaded hi taken", d, 8'h01);
      rd(4'd4, d); chk("R11 loaded lo counting", d, 8'h02);
      t1_mode = 2'b01;
      #1 chk("R7 pin high when disabled", t1_out, 1);
      t1_mode = 2'b00;

      // R8/R9 secondary interval one-shot, N=4
      wr(4'd8, 8'h04); wr(4'd9, 8'h00);              // m=0
      chk("R8 load clears flag", t2_irq, 0);
      rd(4'd8, d); chk("R8 counter lo", d, 8'h04);   // m=1
      rd(4'd9, d); chk("R8 counter hi", d, 8'h00);   // m=2
      tick(2);                                       // m=4
      chk("R9 no flag at N", t2_irq, 0);
      tick(1);                                       // m=5
      chk("R9 flag at N+1", t2_irq, 1);
      rd(4'd9, d); chk("R9 wraps to all ones", d, 8'hFF);   // m=6
      rd(4'd8, d); chk("R9 keeps counting", d, 8'hFE);      // m=7
      chk("R8 read sel8 clears flag", t2_irq, 0);
      tick(100);
      chk("R9 no second flag", t2_irq, 0);

      // R10 pulse counting, N=2
      t2_count_mode = 1'b1;
      wr(4'd8, 8'h02); wr(4'd9, 8'h00);
      tick(10);
      rd(4'd8, d); chk("R10 idle pulse no count", d, 8'h02);
      pulse();
      rd(4'd8, d); chk("R10 one fall one count", d, 8'h01);
      pulse();
      chk("R10 no flag at zero", t2_irq, 0);
      rd(4'd8, d); chk("R10 second fall", d, 8'h00);
      pulse();
      chk("R10 flag past zero", t2_irq, 1);
      rd(4'd9, d); chk("R10 wrap after edge", d, 8'hFF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule